// File: doc/BRIEF.md
# Interrupt Enable and Delegation Register Pair

This block keeps the machine-level interrupt enable word and the interrupt delegation word for one hart. It serves a single CSR access port: an address, a mode input, an operation (read, write, set bits, clear bits) and write data go in. Read data and an illegal-access flag come back in the same cycle. Register updates take effect at the next clock edge.

The supervisor enable and supervisor pending registers have no storage of their own. The block builds them on the fly as views of the machine registers, masked bit by bit by the delegation word. A supervisor write can only reach enable bits whose source has been delegated.

The block also takes a vector of raw pending interrupt lines. It drives the trap logic with the pending-and-enabled vector, recomputed combinationally every cycle.

Top module: `irq_csr_unit`

## Requirements
- R1: After a synchronous reset, the enable word and the delegation word both read as zero.
- R2: A machine-mode access to address 0x304 acts on the enable word, using the operation code on `csr_op_i`: 0 = read, 1 = write, 2 = set, 3 = clear. Write stores the data. Set ORs the data into the current value. Clear removes the bits that are set in the data. The new value reads back from the next cycle on.
- R3: A machine-mode access to address 0x303 acts on the delegation word with the same operation codes as R2.
- R4: Reading address 0x104 returns the enable word ANDed with the delegation word. Every bit whose delegation bit is 0 reads as zero.
- R5: A write, set or clear to address 0x104 first combines the data with the supervisor view, using the operation code. It then changes only those enable bits whose delegation bit is 1. All other enable bits keep their value, even when the write data is all ones.
- R6: Reading address 0x344 returns the raw pending lines. Reading address 0x144 returns the raw pending lines ANDed with the delegation word.
- R7: `csr_illegal_o` is 1 for an enabled access in any of these cases: the address is unknown; the mode is below the privilege level in address bits [9:8]; or the mode is the reserved value. Mode encoding: 3 = machine, 1 = supervisor, 0 = user, 2 = reserved. An illegal access reads zero and changes no state.
- R8: `irq_pend_o` equals `irq_raw_i` ANDed with the enable word, in the same cycle the lines change.
- R9: The read operation changes no state. Writes, sets and clears to addresses 0x344 and 0x144 are accepted and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Current privilege mode (3 M, 1 S, 0 U) |
| csr_en_i | input | 1 | CSR access valid this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | 64 | Write data / bit mask |
| csr_rdata_o | output | 64 | Read data (zero when illegal) |
| csr_illegal_o | output | 1 | Access not permitted |
| irq_raw_i | input | 64 | Raw pending interrupt lines |
| irq_pend_o | output | 64 | Pending and enabled interrupts |

## Verification
The central corner case is a supervisor write of all ones, or a supervisor clear of all ones, while delegation covers only a few bits. A design that skips the delegation mask on the write path would flip machine-only enable bits. Set and clear through the supervisor view are checked against enable words that hold non-delegated ones, which catches a merge done on the raw enable word rather than on the view. Supervisor and user accesses to machine addresses are checked to read zero and leave state intact; a design with a wrong privilege compare would leak data or accept the write. The pending output is checked as the raw lines change with no CSR activity, which catches an output that was registered or tied to the wrong word.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

  localparam int unsigned XLEN = 64;

  localparam logic [11:0] ADDR_MIE     = 12'h304;
  localparam logic [11:0] ADDR_MIDELEG = 12'h303;
  localparam logic [11:0] ADDR_MIP     = 12'h344;
  localparam logic [11:0] ADDR_SIE     = 12'h104;
  localparam logic [11:0] ADDR_SIP     = 12'h144;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    MODE_U   = 2'd0,
    MODE_S   = 2'd1,
    MODE_RSV = 2'd2,
    MODE_M   = 2'd3
  } priv_e;

  typedef struct packed {
    logic hit_men;
    logic hit_dlg;
    logic hit_mpend;
    logic hit_sen;
    logic hit_spend;
    logic illegal;
  } csr_sel_t;

endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_csr_pkg::*;
(
  input  logic        en_i,
  input  logic [1:0]  mode_i,
  input  logic [11:0] addr_i,
  output csr_sel_t    sel_o
);

  logic known;
  logic priv_ok;
  logic mode_rsv;

  always_comb begin
    sel_o    = '0;
    known    = 1'b0;
    mode_rsv = (mode_i == MODE_RSV);
    // Address bits [9:8] carry the lowest mode allowed to touch the register
    priv_ok  = !mode_rsv && (mode_i >= addr_i[9:8]);
    unique case (addr_i)
      ADDR_MIE:     known = 1'b1;
      ADDR_MIDELEG: known = 1'b1;
      ADDR_MIP:     known = 1'b1;
      ADDR_SIE:     known = 1'b1;
      ADDR_SIP:     known = 1'b1;
      default:      known = 1'b0;
    endcase
    sel_o.illegal = en_i && !(known && priv_ok);
    if (en_i && known && priv_ok) begin
      sel_o.hit_men   = (addr_i == ADDR_MIE);
      sel_o.hit_dlg   = (addr_i == ADDR_MIDELEG);
      sel_o.hit_mpend = (addr_i == ADDR_MIP);
      sel_o.hit_sen   = (addr_i == ADDR_SIE);
      sel_o.hit_spend = (addr_i == ADDR_SIP);
    end
  end

endmodule

// File: rtl/irq_csr_merge.sv
module irq_csr_merge
  import irq_csr_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] new_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      unique case (csr_op_e'(op_i))
        OP_WRITE: new_o[b] = data_i[b];
        OP_SET:   new_o[b] = old_i[b] | data_i[b];
        OP_CLEAR: new_o[b] = old_i[b] & ~data_i[b];
        default:  new_o[b] = old_i[b];
      endcase
    end
  end

endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
  import irq_csr_pkg::*;
#(
  parameter int unsigned NSRC = XLEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode_i,
  input  logic            csr_en_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [1:0]      csr_op_i,
  input  logic [NSRC-1:0] csr_wdata_i,
  output logic [NSRC-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  input  logic [NSRC-1:0] irq_raw_i,
  output logic [NSRC-1:0] irq_pend_o
);

  csr_sel_t        sel;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] dlg_q, dlg_d;
  logic [NSRC-1:0] sen_view;
  logic [NSRC-1:0] merge_old, merged;
  logic            wr_op;

  irq_csr_decode u_dec (
    .en_i   (csr_en_i),
    .mode_i (mode_i),
    .addr_i (csr_addr_i),
    .sel_o  (sel)
  );

  assign sen_view = en_q & dlg_q;
  assign wr_op    = (csr_op_e'(csr_op_i) != OP_READ);

  // The merge acts on whatever value the addressed register reads as
  always_comb begin
    if (sel.hit_dlg)      merge_old = dlg_q;
    else if (sel.hit_sen) merge_old = sen_view;
    else                  merge_old = en_q;
  end

  irq_csr_merge #(.W(NSRC)) u_merge (
    .op_i   (csr_op_i),
    .old_i  (merge_old),
    .data_i (csr_wdata_i),
    .new_o  (merged)
  );

  always_comb begin
    en_d  = en_q;
    dlg_d = dlg_q;
    if (wr_op && sel.hit_men) en_d = merged;
    if (wr_op && sel.hit_sen) en_d = (en_q & ~dlg_q) | (merged & dlg_q);
    if (wr_op && sel.hit_dlg) dlg_d = merged;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      dlg_q <= '0;
    end else begin
      en_q  <= en_d;
      dlg_q <= dlg_d;
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    if (sel.hit_men)   csr_rdata_o = en_q;
    if (sel.hit_dlg)   csr_rdata_o = dlg_q;
    if (sel.hit_mpend) csr_rdata_o = irq_raw_i;
    if (sel.hit_sen)   csr_rdata_o = sen_view;
    if (sel.hit_spend) csr_rdata_o = irq_raw_i & dlg_q;
  end

  assign csr_illegal_o = sel.illegal;
  assign irq_pend_o    = irq_raw_i & en_q;

endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk
  import irq_csr_pkg::*;
#(
  parameter int unsigned NSRC = XLEN
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      mode_i,
  input logic            csr_en_i,
  input logic [11:0]     csr_addr_i,
  input logic [1:0]      csr_op_i,
  input logic [NSRC-1:0] csr_rdata_o,
  input logic            csr_illegal_o,
  input logic [NSRC-1:0] irq_raw_i,
  input logic [NSRC-1:0] irq_pend_o,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] dlg_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (en_q == '0) && (dlg_q == '0)); // R1

  AST_SEN_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (csr_en_i && !csr_illegal_o && csr_addr_i == ADDR_SIE) |->
      ((csr_rdata_o & ~dlg_q) == '0)); // R4

  AST_SWRITE_KEEPS_UNDELEG: assert property (@(posedge clk) disable iff (rst)
    (csr_en_i && !csr_illegal_o && csr_addr_i == ADDR_SIE && csr_op_i != 2'd0) |=>
      ((en_q & ~dlg_q) == ($past(en_q) & ~$past(dlg_q)))); // R5

  AST_SPEND_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (csr_en_i && !csr_illegal_o && csr_addr_i == ADDR_SIP) |->
      ((csr_rdata_o & ~(irq_raw_i & dlg_q)) == '0)); // R6

  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    csr_illegal_o |=> ($stable(en_q) && $stable(dlg_q))); // R7

  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    csr_illegal_o |-> (csr_rdata_o == '0)); // R7

  AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (rst)
    ((irq_pend_o & ~irq_raw_i) == '0) && ((irq_pend_o & ~en_q) == '0)); // R8

  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (csr_en_i && csr_op_i == 2'd0) |=> ($stable(en_q) && $stable(dlg_q))); // R9

endmodule

bind irq_csr_unit irq_csr_chk #(.NSRC(NSRC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_i        (mode_i),
  .csr_en_i      (csr_en_i),
  .csr_addr_i    (csr_addr_i),
  .csr_op_i      (csr_op_i),
  .csr_rdata_o   (csr_rdata_o),
  .csr_illegal_o (csr_illegal_o),
  .irq_raw_i     (irq_raw_i),
  .irq_pend_o    (irq_pend_o),
  .en_q          (en_q),
  .dlg_q         (dlg_q)
);

// File: tb/irq_csr_unit_tb_top.sv
module irq_csr_unit_tb_top;

  localparam int unsigned W = 64;
  localparam logic [1:0] MM = 2'd3, MS = 2'd1, MU = 2'd0, MR = 2'd2;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, ST = 2'd2, CL = 2'd3;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic         csr_en;
  logic [11:0]  csr_addr;
  logic [1:0]   csr_op;
  logic [W-1:0] csr_wdata;
  logic [W-1:0] csr_rdata;
  logic         csr_illegal;
  logic [W-1:0] irq_raw;
  logic [W-1:0] irq_pend;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_csr_unit dut_i (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode),
    .csr_en_i      (csr_en),
    .csr_addr_i    (csr_addr),
    .csr_op_i      (csr_op),
    .csr_wdata_i   (csr_wdata),
    .csr_rdata_o   (csr_rdata),
    .csr_illegal_o (csr_illegal),
    .irq_raw_i     (irq_raw),
    .irq_pend_o    (irq_pend)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access: inputs driven at the falling edge, combinational results
  // sampled just after, state committed at the following rising edge.
  task automatic access(input logic [1:0] m, input logic [11:0] a, input logic [1:0] op,
                        input logic [W-1:0] d, output logic [W-1:0] rd, output logic ill);
    @(negedge clk);
    mode = m; csr_addr = a; csr_op = op; csr_wdata = d; csr_en = 1'b1;
    #1;
    rd = csr_rdata; ill = csr_illegal;
    @(posedge clk);
    #1;
    csr_en = 1'b0;
  endtask

  task automatic rd_m(input logic [11:0] a, output logic [W-1:0] rd);
    logic ill;
    access(MM, a, RD, '0, rd, ill);
  endtask

  task automatic wr_m(input logic [11:0] a, input logic [1:0] op, input logic [W-1:0] d);
    logic [W-1:0] rd;
    logic ill;
    access(MM, a, op, d, rd, ill);
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    rd_m(12'h304, v); check("R1 enable after reset", v, '0);
    rd_m(12'h303, v); check("R1 delegation after reset", v, '0);
  endtask

  task automatic t_machine_ops;
    logic [W-1:0] v;
    wr_m(12'h304, WR, 64'hA5A5_0000_FFFF_1234);
    rd_m(12'h304, v); check("R2 write", v, 64'hA5A5_0000_FFFF_1234);
    wr_m(12'h304, ST, 64'h0000_00FF_0000_0001);
    rd_m(12'h304, v); check("R2 set", v, 64'hA5A5_00FF_FFFF_1235);
    wr_m(12'h304, CL, 64'hFFFF_0000_0000_0234);
    rd_m(12'h304, v); check("R2 clear", v, 64'h0000_00FF_FFFF_1001);
    wr_m(12'h304, RD, ONES);
    rd_m(12'h304, v); check("R9 read op leaves enable", v, 64'h0000_00FF_FFFF_1001);
    wr_m(12'h303, WR, 64'h0000_0000_0000_0222);
    wr_m(12'h303, ST, 64'h0000_0000_0000_0800);
    wr_m(12'h303, CL, 64'h0000_0000_0000_0002);
    rd_m(12'h303, v); check("R3 delegation ops", v, 64'h0000_0000_0000_0A20);
  endtask

  task automatic t_sview;
    logic [W-1:0] v;
    logic ill;
    wr_m(12'h304, WR, 64'hF0F0_F0F0_F0F0_F0F0);
    wr_m(12'h303, WR, 64'h00FF_00FF_00FF_00FF);
    access(MS, 12'h104, RD, '0, v, ill);
    check("R4 supervisor enable view", v, 64'h00F0_00F0_00F0_00F0);
    check("R4 no illegal", {63'd0, ill}, '0);
  endtask

  task automatic t_swrite;
    logic [W-1:0] v;
    logic ill;
    logic [W-1:0] dl = 64'h0000_0000_0000_0222;
    wr_m(12'h303, WR, dl);
    wr_m(12'h304, WR, '0);
    access(MS, 12'h104, WR, ONES, v, ill);
    rd_m(12'h304, v); check("R5 all-ones write keeps undelegated", v, dl);
    wr_m(12'h304, WR, ONES);
    access(MS, 12'h104, WR, '0, v, ill);
    rd_m(12'h304, v); check("R5 zero write keeps undelegated", v, ~dl);
    access(MS, 12'h104, ST, 64'h0000_0000_0000_0F00, v, ill);
    rd_m(12'h304, v); check("R5 set via view", v, ~dl | 64'h200);
    access(MS, 12'h104, CL, ONES, v, ill);
    rd_m(12'h304, v); check("R5 clear all via view", v, ~dl);
  endtask

  task automatic t_pending;
    logic [W-1:0] v;
    logic ill;
    wr_m(12'h303, WR, 64'h0000_FFFF_0000_0F0F);
    irq_raw = 64'h1234_5678_9ABC_DEF0;
    rd_m(12'h344, v); check("R6 machine pending read", v, 64'h1234_5678_9ABC_DEF0);
    access(MS, 12'h144, RD, '0, v, ill);
    check("R6 supervisor pending read", v, 64'h0000_5678_0000_0E00);
    wr_m(12'h304, WR, 64'h0000_0000_0000_00F0);
    access(MS, 12'h144, WR, ONES, v, ill);
    wr_m(12'h344, ST, ONES);
    rd_m(12'h304, v); check("R9 pending writes leave enable", v, 64'h0000_0000_0000_00F0);
    rd_m(12'h303, v); check("R9 pending writes leave delegation", v, 64'h0000_FFFF_0000_0F0F);
    irq_raw = '0;
  endtask

  task automatic t_illegal;
    logic [W-1:0] v;
    logic ill;
    wr_m(12'h304, WR, 64'h0000_0000_0000_0AAA);
    wr_m(12'h303, WR, 64'h0000_0000_0000_0F00);
    access(MS, 12'h304, WR, ONES, v, ill);
    check("R7 S to machine enable flagged", {63'd0, ill}, 64'd1);
    check("R7 S to machine enable reads zero", v, '0);
    access(MS, 12'h303, ST, ONES, v, ill);
    check("R7 S to delegation flagged", {63'd0, ill}, 64'd1);
    access(MU, 12'h104, WR, ONES, v, ill);
    check("R7 U to supervisor flagged", {63'd0, ill}, 64'd1);
    access(MR, 12'h304, WR, ONES, v, ill);
    check("R7 reserved mode flagged", {63'd0, ill}, 64'd1);
    access(MM, 12'h305, WR, ONES, v, ill);
    check("R7 unknown address flagged", {63'd0, ill}, 64'd1);
    rd_m(12'h304, v); check("R7 enable unchanged", v, 64'h0000_0000_0000_0AAA);
    rd_m(12'h303, v); check("R7 delegation unchanged", v, 64'h0000_0000_0000_0F00);
  endtask

  task automatic t_irq_out;
    wr_m(12'h304, WR, 64'h8000_0000_0000_0888);
    @(negedge clk);
    irq_raw = 64'hFFFF_0000_0000_0808;
    #1 check("R8 pending output", irq_pend, 64'h8000_0000_0000_0808);
    @(negedge clk);
    irq_raw = 64'h0000_0000_0000_0080;
    #1 check("R8 output follows lines", irq_pend, 64'h0000_0000_0000_0080);
    irq_raw = '0;
    #1 check("R8 output clears", irq_pend, '0);
  endtask

  initial begin
    rst = 1'b1; mode = MM; csr_en = 1'b0; csr_addr = '0; csr_op = RD;
    csr_wdata = '0; irq_raw = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    irq_raw = ONES;
    #1 check("R1 pending output after reset", irq_pend, '0);
    irq_raw = '0;
    t_reset();
    t_machine_ops();
    t_sview();
    t_swrite();
    t_pending();
    t_illegal();
    t_irq_out();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule